// File: doc/BRIEF.md
# Receiver Lock Acquisition Controller

This controller decides what a receive clock-recovery loop locks to: the local reference clock or the incoming serial data. After reset it brings the loop into frequency lock on the reference. Phase acquisition on the data starts only when three things hold: frequency lock has been reached, a signal-detect input reports data, and the active-low lock-to-reference override is released. If the data disappears or the override is asserted, the loop falls back to the reference. The recovered clocks then stay at their nominal rate, and the loop relocks to the data once the data returns.

Both acquisition phases are timed in bit-time ticks, with parameterised limits. Frequency acquisition defaults to 500 µs of bit times and phase acquisition to 2500 bit times. If a limit expires, a sticky error flag is raised and frequency acquisition is restarted. The analog loop, the phase detector and the loop filter are outside the block. They reach it only through the frequency-lock and phase-lock indications.

There are four states:
- `ST_FREQ`: frequency acquisition on the reference. This is the state the synchronous reset enters.
- `ST_PHASE`: phase acquisition on the data.
- `ST_LOCKED`: locked to the data.
- `ST_LOST`: reference hold while there is no usable data.

The transitions are:
- FREQ→PHASE: frequency lock is reached, data is present and the override is released.
- FREQ→LOST: frequency lock is reached, but there is no data or the override is asserted.
- FREQ→FREQ: the frequency limit expires; the timer restarts.
- LOST→PHASE: data appears or the override is released.
- LOST→FREQ: frequency lock is lost.
- PHASE→LOCKED: the phase-lock indication is seen.
- PHASE→FREQ: the phase limit expires.
- PHASE/LOCKED→LOST: the signal is lost or the override is asserted.
- LOCKED→PHASE: phase lock is lost.

Top module: `rx_lock_ctrl`

## Requirements
- R1: A synchronous reset `rst` enters ST_FREQ and clears the timer and `acq_err`. After reset, `track_data`, `phase_acq_en`, `locked` and `acq_err` are all 0.
- R2: In ST_FREQ, `freq_lock`=1 together with `sig_det`=1 and `ref_lock_n`=1 moves the block to ST_PHASE on the next clock edge. In ST_PHASE, `track_data`=1 (data mode), `phase_acq_en`=1 and `locked`=0.
- R3: When frequency lock is reached without data, the block holds the reference (ST_LOST) with `track_data`=0. It never times out there. It moves to ST_PHASE on the edge after `sig_det` rises.
- R4: While `ref_lock_n`=0, the block is in reference mode one edge later (`track_data`=0) and stays there, whatever `sig_det`, `freq_lock` and `phase_lock` do. Releasing the override with data present starts phase acquisition.
- R5: In ST_PHASE, `phase_lock`=1 enters ST_LOCKED on the next edge. `locked`=1 only in ST_LOCKED, and there `track_data`=1 and `phase_acq_en`=1.
- R6: If `sig_det` falls in ST_PHASE or ST_LOCKED, the block is in ST_LOST one edge later, with `locked`=0 and `track_data`=0. When the data returns, it relocks through ST_PHASE to ST_LOCKED.
- R7: If ST_PHASE sees PHASE_TICKS bit ticks without phase lock, the block returns to ST_FREQ and sets `acq_err`. The edge carrying the PHASE_TICKS-th tick makes the change.
- R8: If ST_FREQ sees FREQ_TICKS bit ticks without frequency lock, `acq_err` is set and the frequency timer restarts, while the block stays in reference mode.
- R9: `acq_err` stays 1 until the block enters ST_LOCKED or is reset.
- R10: Timers advance only on clock edges where `bit_tick`=1. Without ticks, no timeout occurs.
- R11: If ST_LOCKED loses `phase_lock`, the block goes back to ST_PHASE with `locked`=0 and a freshly cleared phase timer.
- R12: If ST_LOST loses `freq_lock`, the block re-enters ST_FREQ with a freshly cleared frequency timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_lock_n | input | 1 | Lock-to-reference override, active low |
| sig_det | input | 1 | Incoming serial data present |
| freq_lock | input | 1 | Loop frequency-locked to the reference |
| phase_lock | input | 1 | Loop phase-locked to the data |
| bit_tick | input | 1 | One pulse per bit time |
| track_data | output | 1 | Loop source select: 1 = data, 0 = reference |
| phase_acq_en | output | 1 | Enables the data phase detector |
| locked | output | 1 | Locked to the data |
| acq_err | output | 1 | Sticky acquisition-timeout flag |

## Verification
A wrong state shows up at the outputs on the first edge after the faulty transition. Entering data mode too early, or staying in it, raises `track_data` while the override is asserted or the signal is absent. A stuck `locked` stays high after signal loss. Timer faults show up as `acq_err` rising one edge early or late relative to the PHASE_TICKS-th or FREQ_TICKS-th tick. The reference-hold state is told apart from frequency acquisition at the ports by whether `acq_err` appears after a full frequency window.

// File: rtl/lock_pkg.sv
package lock_pkg;
    typedef enum logic [1:0] {
        ST_FREQ   = 2'd0,
        ST_PHASE  = 2'd1,
        ST_LOCKED = 2'd2,
        ST_LOST   = 2'd3
    } lock_state_t;
endpackage

// File: rtl/lock_tick_timer.sv
module lock_tick_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    // expiry on the edge that carries the limit-th tick since clear
    assign expired = tick && (cnt == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
    import lock_pkg::*;
(
    input  lock_state_t st,
    input  logic        ref_lock_n,
    input  logic        sig_det,
    input  logic        freq_lock,
    input  logic        phase_lock,
    input  logic        tmr_exp,
    output lock_state_t nxt,
    output logic        to_err
);
    logic data_ok;
    assign data_ok = ref_lock_n && sig_det;

    always_comb begin
        nxt    = st;
        to_err = 1'b0;
        unique case (st)
            ST_FREQ: begin
                if (freq_lock)
                    nxt = data_ok ? ST_PHASE : ST_LOST;
                else if (tmr_exp)
                    to_err = 1'b1;
            end
            ST_LOST: begin
                if (!freq_lock)
                    nxt = ST_FREQ;
                else if (data_ok)
                    nxt = ST_PHASE;
            end
            ST_PHASE: begin
                if (!data_ok)
                    nxt = ST_LOST;
                else if (phase_lock)
                    nxt = ST_LOCKED;
                else if (tmr_exp) begin
                    nxt    = ST_FREQ;
                    to_err = 1'b1;
                end
            end
            ST_LOCKED: begin
                if (!data_ok)
                    nxt = ST_LOST;
                else if (!phase_lock)
                    nxt = ST_PHASE;
            end
            default: nxt = ST_FREQ;
        endcase
    end
endmodule

// File: rtl/rx_lock_ctrl.sv
module rx_lock_ctrl
    import lock_pkg::*;
#(
    parameter int FREQ_TICKS  = 531250,
    parameter int PHASE_TICKS = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_lock_n,
    input  logic sig_det,
    input  logic freq_lock,
    input  logic phase_lock,
    input  logic bit_tick,
    output logic track_data,
    output logic phase_acq_en,
    output logic locked,
    output logic acq_err
);
    localparam int MAX_TICKS = (FREQ_TICKS > PHASE_TICKS) ? FREQ_TICKS : PHASE_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] FREQ_LIM  = CNT_W'(FREQ_TICKS);
    localparam logic [CNT_W-1:0] PHASE_LIM = CNT_W'(PHASE_TICKS);

    lock_state_t      st, nxt;
    logic             to_err, tmr_exp, tmr_clr, timing, tick_en;
    logic [CNT_W-1:0] limit;

    assign timing  = (st == ST_FREQ) || (st == ST_PHASE);
    assign tick_en = bit_tick && timing;
    assign limit   = (st == ST_PHASE) ? PHASE_LIM : FREQ_LIM;
    assign tmr_clr = rst || !timing || (nxt != st) || tmr_exp;

    lock_tick_timer #(.CNT_W(CNT_W)) tmr_i (
        .clk     (clk),
        .clr     (tmr_clr),
        .tick    (tick_en),
        .limit   (limit),
        .expired (tmr_exp)
    );

    lock_next_state nxt_i (
        .st         (st),
        .ref_lock_n (ref_lock_n),
        .sig_det    (sig_det),
        .freq_lock  (freq_lock),
        .phase_lock (phase_lock),
        .tmr_exp    (tmr_exp),
        .nxt        (nxt),
        .to_err     (to_err)
    );

    // state register and sticky error flag
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_FREQ;
            acq_err <= 1'b0;
        end else begin
            st <= nxt;
            if (nxt == ST_LOCKED && st != ST_LOCKED)
                acq_err <= 1'b0;
            else if (to_err)
                acq_err <= 1'b1;
        end
    end

    // Moore output decode
    always_comb begin
        track_data   = 1'b0;
        phase_acq_en = 1'b0;
        locked       = 1'b0;
        unique case (st)
            ST_FREQ, ST_LOST: ;
            ST_PHASE: begin
                track_data   = 1'b1;
                phase_acq_en = 1'b1;
            end
            ST_LOCKED: begin
                track_data   = 1'b1;
                phase_acq_en = 1'b1;
                locked       = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rx_lock_ctrl_chk.sv
module rx_lock_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ref_lock_n,
    input logic sig_det,
    input logic freq_lock,
    input logic track_data,
    input logic phase_acq_en,
    input logic locked,
    input logic acq_err
);
    p_locked_data_r5: assert property (@(posedge clk) disable iff (rst)
        locked |-> (track_data && phase_acq_en));

    p_override_ref_r4: assert property (@(posedge clk) disable iff (rst)
        !ref_lock_n |=> !track_data);

    p_sigloss_unlock_r6: assert property (@(posedge clk) disable iff (rst)
        !sig_det |=> !locked);

    p_data_needs_freq_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(track_data) |-> $past(freq_lock));

    p_err_to_ref_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(acq_err) |-> !track_data);
endmodule

bind rx_lock_ctrl rx_lock_ctrl_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .ref_lock_n   (ref_lock_n),
    .sig_det      (sig_det),
    .freq_lock    (freq_lock),
    .track_data   (track_data),
    .phase_acq_en (phase_acq_en),
    .locked       (locked),
    .acq_err      (acq_err)
);

// File: tb/rx_lock_ctrl_tb_top.sv
module rx_lock_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FT = 12;
    localparam int PT = 10;

    // expected {track_data, phase_acq_en, locked, acq_err}
    localparam logic [3:0] REF   = 4'b0000;
    localparam logic [3:0] REFE  = 4'b0001;
    localparam logic [3:0] PHS   = 4'b1100;
    localparam logic [3:0] PHSE  = 4'b1101;
    localparam logic [3:0] LCK   = 4'b1110;

    logic clk = 1'b0;
    logic rst, ref_lock_n, sig_det, freq_lock, phase_lock, bit_tick;
    logic track_data, phase_acq_en, locked, acq_err;
    int   vectors = 0;
    int   fails   = 0;
    bit   done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_lock_ctrl #(.FREQ_TICKS(FT), .PHASE_TICKS(PT)) dut_i (
        .clk(clk), .rst(rst), .ref_lock_n(ref_lock_n), .sig_det(sig_det),
        .freq_lock(freq_lock), .phase_lock(phase_lock), .bit_tick(bit_tick),
        .track_data(track_data), .phase_acq_en(phase_acq_en),
        .locked(locked), .acq_err(acq_err)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] got;
        got = {track_data, phase_acq_en, locked, acq_err};
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%b exp=%b", req, got, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; ref_lock_n = 1'b1; sig_det = 1'b0;
        freq_lock = 1'b0; phase_lock = 1'b0; bit_tick = 1'b1;
        step(2);
        rst = 1'b0;
        chk("R1 reset state", REF);
    endtask

    task automatic t_auto_lock();
        freq_lock = 1'b1; sig_det = 1'b1;
        step(1); chk("R2 freq lock to phase acq", PHS);
        phase_lock = 1'b1;
        step(1); chk("R5 phase lock to locked", LCK);
    endtask

    task automatic t_sig_loss();
        sig_det = 1'b0;
        step(1); chk("R6 signal loss drops lock", REF);
        step(2 * FT); chk("R3 reference hold no timeout", REF);
        sig_det = 1'b1;
        step(1); chk("R3 data return starts phase acq", PHS);
        step(1); chk("R6 relock after return", LCK);
    endtask

    task automatic t_override();
        ref_lock_n = 1'b0;
        step(1); chk("R4 override forces reference", REF);
        step(2 * FT); chk("R4 data ignored under override", REF);
        ref_lock_n = 1'b1;
        step(1); chk("R4 release starts phase acq", PHS);
        step(1); chk("R4 relock after release", LCK);
    endtask

    task automatic t_phase_timeout();
        phase_lock = 1'b0;
        step(1); chk("R11 phase loss back to phase acq", PHS);
        freq_lock = 1'b0;
        step(PT - 1); chk("R7 no timeout before limit", PHS);
        step(1); chk("R7 phase timeout to freq acq with error", REFE);
        step(3); chk("R9 error stays set", REFE);
    endtask

    task automatic t_freq_timeout();
        do_reset();
        chk("R9 reset clears error", REF);
        bit_tick = 1'b0;
        step(3 * FT); chk("R10 no ticks no timeout", REF);
        bit_tick = 1'b1;
        step(FT - 1); chk("R8 no timeout before limit", REF);
        step(1); chk("R8 freq timeout sets error", REFE);
        freq_lock = 1'b1; sig_det = 1'b1;
        step(1); chk("R9 error kept in phase acq", PHSE);
        phase_lock = 1'b1;
        step(1); chk("R9 error cleared on lock", LCK);
    endtask

    task automatic t_lost_freq_drop();
        sig_det = 1'b0;
        step(1); chk("R6 loss to reference hold", REF);
        freq_lock = 1'b0;
        step(FT); chk("R12 freq window restarted", REF);
        step(1); chk("R12 freq acq timer expires", REFE);
    endtask

    initial begin
        do_reset();
        t_auto_lock();
        t_sig_loss();
        t_override();
        t_phase_timeout();
        t_freq_timeout();
        t_lost_freq_drop();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired got=hang exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule